// File: doc/BRIEF.md
# Parallel DDR Sample Reassembler

This block sits behind the input buffers of a converter capture path. It receives a double-data-rate lane bus that has already been turned into single-ended signals, together with the forwarded clock that strobes it. It captures the lanes on both edges of that clock and rebuilds full-width converter samples. Each sample comes with a valid strobe. A two-bit mode input picks how the lanes are to be read. In the bit-interleaved layout, each lane carries one odd bit and one even bit of the same sample. In the whole-word layout, each edge carries a complete sample. In the dual-channel interleaved layout, the lanes are split in half and each half carries one channel in the bit-interleaved layout.

The rising-edge lane values and the falling-edge lane values go into two separate registers. The following rising edge merges them into one output word. The block has two output slots, which makes it possible to deliver two samples per clock period: in the whole-word layout the earlier sample appears in slot 0 and the later one in slot 1, and in the dual-channel layout the two slots carry the two channels. Output bits above the active resolution read zero. Lanes that the active layout does not use have no effect.

Top module: `ddr_sample_reassembler`

## Requirements
- R1: While rst_ni is low, smp0_o, smp1_o, smp0_vld_o and smp1_vld_o are all zero. This applies as soon as reset is asserted, without waiting for a clock edge.
- R2: Reset is released between two rising edges. The first rising edge after release captures lanes, and so does the falling edge that follows it. smp0_vld_o stays low after that first rising edge and first goes high after the second rising edge.
- R3: mode_i = 0 selects the bit-interleaved layout (code 3 behaves the same). Take the lane values captured on rising edge n and on the falling edge after it. For each lane k below BIT_RES/2, the rising-edge value goes to bit 2k+1 of smp0_o and the falling-edge value goes to bit 2k. The word appears just after rising edge n+1, with smp0_vld_o high.
- R4: In the bit-interleaved layout, smp1_vld_o stays low and smp1_o stays zero. Lanes at index BIT_RES/2 and above have no effect on the output.
- R5: mode_i = 1 selects the whole-word layout. Lanes [WORD_RES-1:0] captured on rising edge n go to smp0_o, which is the earlier sample. Lanes captured on the falling edge after it go to smp1_o. Both slots are valid together, just after rising edge n+1.
- R6: In the whole-word and dual-channel layouts, output bits at index WORD_RES (or DUAL_RES) and above are zero. This holds whatever the lanes carry.
- R7: mode_i = 2 selects the dual-channel layout. Lanes [DUAL_RES/2-1:0] are mapped as in R3 into smp0_o (channel A). The next DUAL_RES/2 lanes are mapped the same way into smp1_o (channel B). Both slots are valid together.
- R8: Once smp0_vld_o is high, it stays high on every cycle until reset. A new output word appears after every rising edge.
- R9: An output slot whose valid is low presents all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Forwarded DDR lane clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Layout: 0 bit-interleaved, 1 whole-word, 2 dual-channel, 3 as 0 |
| lane_i | input | LANES | Single-ended DDR data lanes |
| smp0_o | output | OUT_W | Slot 0 sample: single sample, earlier sample, or channel A |
| smp0_vld_o | output | 1 | Slot 0 valid |
| smp1_o | output | OUT_W | Slot 1 sample: later sample or channel B |
| smp1_vld_o | output | 1 | Slot 1 valid |

## Verification
Several rules are checked by assertions on every cycle:
- slot 1 is never valid without slot 0;
- slot 1 stays idle in the bit-interleaved layout;
- valid holds once it has risen;
- an idle slot reads zero;
- the high bits of a whole-word sample are zero;
- lane 0 of the bit-interleaved layout lands on bits 1 and 0 one edge after capture.

Other behaviours can only be shown by the bench's scenarios:
- the full lane-to-bit mapping in all layouts;
- the ordering of the two edges within a period;
- the exact startup latency after a mid-cycle reset release;
- the fact that garbage on unused lanes never reaches the outputs.

// File: rtl/ddr_reasm_pkg.sv
`timescale 1ns/1ps
package ddr_reasm_pkg;

  typedef enum logic [1:0] {
    MODE_BIT  = 2'd0,
    MODE_WORD = 2'd1,
    MODE_DUAL = 2'd2,
    MODE_RSVD = 2'd3
  } ddr_mode_e;

  function automatic logic is_bit_mode(input ddr_mode_e m);
    return (m == MODE_BIT) || (m == MODE_RSVD);
  endfunction

endpackage

// File: rtl/ddr_edge_capture.sv
`timescale 1ns/1ps
// Rising- and falling-edge lane registers, each with a seen flag since reset.
module ddr_edge_capture #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic         rise_seen_o,
  output logic         fall_seen_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_o      <= '0;
      rise_seen_o <= 1'b0;
    end else begin
      rise_o      <= d_i;
      rise_seen_o <= 1'b1;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_o      <= '0;
      fall_seen_o <= 1'b0;
    end else begin
      fall_o      <= d_i;
      fall_seen_o <= 1'b1;
    end
  end

endmodule

// File: rtl/bit_pair_unpack.sv
`timescale 1ns/1ps
// Lane k: rising value -> bit 2k+1, falling value -> bit 2k; upper bits zero.
module bit_pair_unpack #(
  parameter int PAIRS = 8,
  parameter int OUT_W = 16
) (
  input  logic [PAIRS-1:0] rise_i,
  input  logic [PAIRS-1:0] fall_i,
  output logic [OUT_W-1:0] word_o
);

  localparam int USED = 2 * PAIRS;

  logic [USED-1:0] packed_w;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign packed_w[2*k+1] = rise_i[k];
    assign packed_w[2*k]   = fall_i[k];
  end

  if (USED < OUT_W) begin : g_pad
    assign word_o = {{(OUT_W-USED){1'b0}}, packed_w};
  end else begin : g_full
    assign word_o = packed_w[OUT_W-1:0];
  end

endmodule

// File: rtl/lane_word_fill.sv
`timescale 1ns/1ps
// Whole-word lanes to output width with zero fill above the resolution.
module lane_word_fill #(
  parameter int RES   = 14,
  parameter int OUT_W = 16
) (
  input  logic [RES-1:0]   lanes_i,
  output logic [OUT_W-1:0] word_o
);

  if (RES < OUT_W) begin : g_pad
    assign word_o = {{(OUT_W-RES){1'b0}}, lanes_i};
  end else begin : g_full
    assign word_o = lanes_i[OUT_W-1:0];
  end

endmodule

// File: rtl/ddr_sample_reassembler.sv
`timescale 1ns/1ps
module ddr_sample_reassembler
  import ddr_reasm_pkg::*;
#(
  parameter int LANES    = 14,
  parameter int OUT_W    = 16,
  parameter int BIT_RES  = 16,
  parameter int WORD_RES = 14,
  parameter int DUAL_RES = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [LANES-1:0] lane_i,
  output logic [OUT_W-1:0] smp0_o,
  output logic             smp0_vld_o,
  output logic [OUT_W-1:0] smp1_o,
  output logic             smp1_vld_o
);

  localparam int BIT_LANES  = BIT_RES / 2;
  localparam int DUAL_LANES = DUAL_RES / 2;

  logic [LANES-1:0] cap_rise, cap_fall;
  logic             rise_seen, fall_seen;
  logic             pair_ok;
  ddr_mode_e        mode_q;

  logic [OUT_W-1:0] bit_word, word_early, word_late, dual_a, dual_b;
  logic [OUT_W-1:0] nxt0, nxt1;
  logic             nxt_v0, nxt_v1;

  ddr_edge_capture #(.W(LANES)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .d_i         (lane_i),
    .rise_o      (cap_rise),
    .fall_o      (cap_fall),
    .rise_seen_o (rise_seen),
    .fall_seen_o (fall_seen)
  );

  bit_pair_unpack #(.PAIRS(BIT_LANES), .OUT_W(OUT_W)) u_bit (
    .rise_i (cap_rise[BIT_LANES-1:0]),
    .fall_i (cap_fall[BIT_LANES-1:0]),
    .word_o (bit_word)
  );

  lane_word_fill #(.RES(WORD_RES), .OUT_W(OUT_W)) u_early (
    .lanes_i (cap_rise[WORD_RES-1:0]),
    .word_o  (word_early)
  );

  lane_word_fill #(.RES(WORD_RES), .OUT_W(OUT_W)) u_late (
    .lanes_i (cap_fall[WORD_RES-1:0]),
    .word_o  (word_late)
  );

  bit_pair_unpack #(.PAIRS(DUAL_LANES), .OUT_W(OUT_W)) u_dual_a (
    .rise_i (cap_rise[DUAL_LANES-1:0]),
    .fall_i (cap_fall[DUAL_LANES-1:0]),
    .word_o (dual_a)
  );

  bit_pair_unpack #(.PAIRS(DUAL_LANES), .OUT_W(OUT_W)) u_dual_b (
    .rise_i (cap_rise[2*DUAL_LANES-1:DUAL_LANES]),
    .fall_i (cap_fall[2*DUAL_LANES-1:DUAL_LANES]),
    .word_o (dual_b)
  );

  // A pair is complete once a rising capture and the falling one after it exist.
  assign pair_ok = rise_seen & fall_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_BIT;
    else         mode_q <= ddr_mode_e'(mode_i);
  end

  always_comb begin
    nxt0   = '0;
    nxt1   = '0;
    nxt_v0 = 1'b0;
    nxt_v1 = 1'b0;
    if (pair_ok) begin
      unique case (mode_q)
        MODE_WORD: begin
          nxt0 = word_early; nxt1 = word_late;
          nxt_v0 = 1'b1;     nxt_v1 = 1'b1;
        end
        MODE_DUAL: begin
          nxt0 = dual_a;     nxt1 = dual_b;
          nxt_v0 = 1'b1;     nxt_v1 = 1'b1;
        end
        default: begin
          nxt0 = bit_word;
          nxt_v0 = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp0_o     <= '0;
      smp1_o     <= '0;
      smp0_vld_o <= 1'b0;
      smp1_vld_o <= 1'b0;
    end else begin
      smp0_o     <= nxt0;
      smp1_o     <= nxt1;
      smp0_vld_o <= nxt_v0;
      smp1_vld_o <= nxt_v1;
    end
  end

  AST_SLOT1_NEEDS_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp1_vld_o |-> smp0_vld_o); // R5

  AST_BIT_SLOT1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp0_vld_o && is_bit_mode(mode_q)) |-> !smp1_vld_o); // R4

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(smp0_vld_o) |-> smp0_vld_o); // R8

  AST_IDLE0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp0_vld_o |-> (smp0_o == '0)); // R9

  AST_IDLE1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp1_vld_o |-> (smp1_o == '0)); // R9

  AST_BIT_LANE0_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_ok && is_bit_mode(mode_q)) |=>
      (smp0_o[1] == $past(cap_rise[0])) && (smp0_o[0] == $past(cap_fall[0]))); // R3

  if (WORD_RES < OUT_W) begin : g_fill_chk
    AST_WORD_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp0_vld_o && mode_q == MODE_WORD) |->
        (smp0_o[OUT_W-1:WORD_RES] == '0) && (smp1_o[OUT_W-1:WORD_RES] == '0)); // R6
  end

endmodule

// File: tb/tb_ddr_sample_reassembler.sv
`timescale 1ns/1ps
module tb_ddr_sample_reassembler;

  localparam int LANES = 14;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode_r = 2'd0;
  logic [LANES-1:0] lane_r = '0;
  logic [OUT_W-1:0] smp0, smp1;
  logic             v0, v1;

  int n_chk = 0;
  int n_bad = 0;

  ddr_sample_reassembler dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_r), .lane_i(lane_r),
    .smp0_o(smp0), .smp0_vld_o(v0), .smp1_o(smp1), .smp1_vld_o(v1)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [LANES-1:0] enc_bit(input logic [15:0] s, input logic odd,
                                                input logic [LANES-1:0] junk);
    logic [LANES-1:0] r = junk;
    for (int k = 0; k < 8; k++) r[k] = odd ? s[2*k+1] : s[2*k];
    return r;
  endfunction

  function automatic logic [LANES-1:0] enc_dual(input logic [13:0] a, input logic [13:0] b,
                                                 input logic odd);
    logic [LANES-1:0] r = '0;
    for (int k = 0; k < 7; k++) begin
      r[k]   = odd ? a[2*k+1] : a[2*k];
      r[7+k] = odd ? b[2*k+1] : b[2*k];
    end
    return r;
  endfunction

  function automatic logic [15:0] pick(input int i, input logic [15:0] rnd);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'hAAAA;
      3: return 16'h5555;
      default: return rnd;
    endcase
  endfunction

  task automatic run_stream(input logic [1:0] mode, input int count);
    logic [15:0] pa, pb, a, b;
    logic        have_prev;
    logic [LANES-1:0] rl, fl;
    rst_ni = 1'b0;
    mode_r = mode;
    lane_r = LANES'($urandom);
    #1;
    chk("R1 reset smp0", smp0, 0); chk("R1 reset vld0", v0, 0);
    chk("R1 reset smp1", smp1, 0); chk("R1 reset vld1", v1, 0);
    @(posedge clk); #3;
    rst_ni = 1'b1;
    have_prev = 1'b0;
    pa = '0; pb = '0;
    for (int i = 0; i < count; i++) begin
      a = pick(i, 16'($urandom));
      b = pick((i + 2) % 4 + (i >= 4 ? 4 : 0), 16'($urandom));
      case (mode)
        2'd1: begin
          a = a & 16'h3FFF; b = b & 16'h3FFF;
          rl = a[13:0]; fl = b[13:0];
        end
        2'd2: begin
          a = a & 16'h3FFF; b = b & 16'h3FFF;
          rl = enc_dual(a[13:0], b[13:0], 1'b1);
          fl = enc_dual(a[13:0], b[13:0], 1'b0);
        end
        default: begin
          b = '0;
          rl = enc_bit(a, 1'b1, LANES'($urandom));
          fl = enc_bit(a, 1'b0, LANES'($urandom));
        end
      endcase
      @(negedge clk); #5 lane_r = rl;
      @(posedge clk); #5;
      if (!have_prev) begin
        chk("R2 R9 no valid before second edge", {v1, v0}, 0);
        chk("R9 idle data", {smp1, smp0}, 0);
      end else begin
        check_out(mode, pa, pb, i == 1);
      end
      lane_r = fl;
      pa = a; pb = b; have_prev = 1'b1;
    end
    @(posedge clk); #5;
    check_out(mode, pa, pb, 1'b0);
    #4 rst_ni = 1'b0;
    #1;
    chk("R1 async reset vld", {v1, v0}, 0);
    chk("R1 async reset data", {smp1, smp0}, 0);
  endtask

  task automatic check_out(input logic [1:0] mode, input logic [15:0] ea,
                           input logic [15:0] eb, input logic first);
    if (first) chk("R2 first valid", v0, 1);
    case (mode)
      2'd1: begin
        chk("R8 vld0", v0, 1);
        chk("R5 R6 earlier sample", smp0, ea);
        chk("R5 vld1", v1, 1);
        chk("R5 R6 later sample", smp1, eb);
      end
      2'd2: begin
        chk("R8 vld0", v0, 1);
        chk("R7 R6 channel A", smp0, ea);
        chk("R7 vld1", v1, 1);
        chk("R7 R6 channel B", smp1, eb);
      end
      default: begin
        chk("R8 vld0", v0, 1);
        chk("R3 bit-interleaved sample", smp0, ea);
        chk("R4 slot1 vld", v1, 0);
        chk("R4 R9 slot1 data", smp1, 0);
      end
    endcase
  endtask

  initial begin
    #(64'd20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    repeat (2) @(posedge clk);
    run_stream(2'd0, 300);
    run_stream(2'd1, 300);
    run_stream(2'd2, 300);
    run_stream(2'd3, 40);
    run_stream(2'd1, 20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule